// File: doc/BRIEF.md
# Boundary-Safe Burst Write Master

This block is a write-DMA engine. It drains a run of 32-bit words from a local show-ahead source FIFO and writes them to memory through a burst-capable memory-mapped master port. The memory behind that port wraps addresses inside its native burst window. A burst that starts part-way into a window and runs past its end would therefore store words at the wrong locations. To prevent this, the engine picks each burst's length from the current address and the words still left.

The first burst depends on the start address. When the start address lies part-way into a 16-byte window, the engine first issues a short burst that reaches the next 16-byte boundary. After that it issues full aligned bursts of 16 beats, and a final burst carries whatever remains. When the start address is already on a boundary, there is no short leading burst.

The master stalls on waitrequest. It also pauses whenever the source runs dry. It reports completion with a single-cycle pulse.

Top module: `align_burst_writer`

## Requirements
- R1: While reset is held and right after it is released, memWrite, busy and done are all 0.
- R2: Word i of a transfer, taken from the source in FIFO order, is written at byte address startAddr + 4*i. Exactly wordCount words are written. Every address driven on memAddr has its two low bits at 0.
- R3: When startAddr has a nonzero low nibble (0x4, 0x8 or 0xC), the first burst carries min(wordCount, (16 - lowNibble)/4) beats, that is 3, 2 or 1 when enough words remain.
- R4: When the low nibble of startAddr is 0, the first burst carries min(wordCount, 16) beats, with no short leading burst.
- R5: Every burst after the first starts at an address that is a multiple of 16 and carries min(words remaining, 16) beats.
- R6: memBurst is always between 1 and 16 while memWrite is high. A burst whose address is not a multiple of 16 ends at or before the next 16-byte boundary.
- R7: While memWrite is high and memWaitReq is high, memAddr and memBurst hold their values. A beat counts only on a cycle with memWrite high and memWaitReq low, and each such beat pops exactly one source word. memWrite stays low while the source is empty.
- R8: With the source holding data, the first beat is presented 2 cycles after the cycle in which start is sampled. done is a one-cycle pulse 2 cycles after the final accepted beat. busy is 0 again after done.
- R9: A start with wordCount 0 produces no write and pulses done 2 cycles after start.
- R10: A start pulse that arrives while busy is 1 is ignored: the running transfer completes unchanged and no further transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| startAddr | input | 32 | Byte address of the first word |
| wordCount | input | 16 | Number of 32-bit words to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| srcData | input | 32 | Head word of the source FIFO |
| srcValid | input | 1 | Source FIFO holds a word |
| srcRead | output | 1 | Pop the source FIFO head |
| memAddr | output | 32 | Burst start byte address |
| memBurst | output | 5 | Beats in the current burst |
| memWrite | output | 1 | Write beat valid |
| memWdata | output | 32 | Write beat data |
| memWaitReq | input | 1 | Memory stall |

## Verification
The bench drives start on a falling edge and counts cycles from the rising edge that samples it. It expects memWrite at the falling edge two cycles later and, for a zero count, done at that same point. It logs every accepted beat and every burst header at falling edges, after the stall and gap inputs for that cycle have settled. It then expects done exactly two cycles after the last logged beat. Burst headers are compared against a list that the bench computes from the start offset and the word count. Stored words are checked once busy has been low for several cycles, so that any late or extra beat would show up in the write total.

// File: rtl/abw_pkg.sv
package abw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_BURST,
    ST_FIN
  } abwState_e;

  typedef struct packed {
    logic load;    // capture start address and count
    logic launch;  // fix next burst address and length
    logic beat;    // one write beat accepted
  } abwStrobe_t;
endpackage

// File: rtl/abw_datapath.sv
module abw_datapath
  import abw_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 16,
  parameter int MAX_BURST      = 16,
  parameter int ALIGN_BYTES    = 16,
  parameter int BYTES_PER_WORD = 4,
  parameter int BC_W           = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  abwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BC_W-1:0]   memBurst,
  output logic              remZero,
  output logic              lastBeat
);
  localparam int OFF_W           = $clog2(ALIGN_BYTES);
  localparam int WORDS_PER_ALIGN = ALIGN_BYTES / BYTES_PER_WORD;

  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] burstAddr;
  logic [CNT_W-1:0]  remWords;
  logic [BC_W-1:0]   burstLen;
  logic [BC_W-1:0]   beatsLeft;

  logic [OFF_W-1:0]  offset;
  logic [CNT_W-1:0]  roomRaw;
  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  lenPick;

  assign offset = nextAddr[OFF_W-1:0];

  // Words that fit before the next boundary; an aligned address may run a full burst.
  always_comb begin
    if (offset == '0) begin
      roomRaw = CNT_W'(MAX_BURST);
    end else begin
      roomRaw = CNT_W'((ALIGN_BYTES - int'(offset)) / BYTES_PER_WORD);
    end
  end

  generate
    if (WORDS_PER_ALIGN > MAX_BURST) begin : g_capRoom
      assign room = (roomRaw > CNT_W'(MAX_BURST)) ? CNT_W'(MAX_BURST) : roomRaw;
    end else begin : g_plainRoom
      assign room = roomRaw;
    end
  endgenerate

  assign lenPick = (remWords < room) ? remWords : room;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr  <= '0;
      burstAddr <= '0;
      remWords  <= '0;
      burstLen  <= '0;
      beatsLeft <= '0;
    end else begin
      if (strobe.load) begin
        nextAddr <= startAddr & ~ADDR_W'(BYTES_PER_WORD - 1);
        remWords <= wordCount;
      end else if (strobe.beat) begin
        nextAddr <= nextAddr + ADDR_W'(BYTES_PER_WORD);
        remWords <= remWords - CNT_W'(1);
      end

      if (strobe.launch) begin
        burstAddr <= nextAddr;
        burstLen  <= BC_W'(lenPick);
        beatsLeft <= BC_W'(lenPick);
      end else if (strobe.beat) begin
        beatsLeft <= beatsLeft - BC_W'(1);
      end
    end
  end

  assign memAddr  = burstAddr;
  assign memBurst = burstLen;
  assign remZero  = (remWords == '0);
  assign lastBeat = (beatsLeft == BC_W'(1));
endmodule

// File: rtl/abw_ctrl.sv
module abw_ctrl
  import abw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       remZero,
  input  logic       lastBeat,
  input  logic       srcValid,
  input  logic       memWaitReq,
  output abwStrobe_t strobe,
  output logic       memWrite,
  output logic       srcRead,
  output logic       busy,
  output logic       done
);
  abwState_e state;
  abwState_e stateNext;
  logic      accept;

  assign memWrite = (state == ST_BURST) && srcValid;
  assign accept   = memWrite && !memWaitReq;
  assign srcRead  = accept;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == ST_IDLE) && start;
    strobe.launch = (state == ST_PICK) && !remZero;
    strobe.beat   = accept;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_PICK;
      ST_PICK:  stateNext = remZero ? ST_FIN : ST_BURST;
      ST_BURST: if (accept && lastBeat) stateNext = ST_PICK;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/align_burst_writer.sv
module align_burst_writer
  import abw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int MAX_BURST   = 16,
  parameter int ALIGN_BYTES = 16,
  localparam int BC_W       = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  output logic              srcRead,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BC_W-1:0]   memBurst,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memWaitReq
);
  localparam int BYTES_PER_WORD = DATA_W / 8;

  abwStrobe_t strobe;
  logic       remZero;
  logic       lastBeat;

  abw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .remZero    (remZero),
    .lastBeat   (lastBeat),
    .srcValid   (srcValid),
    .memWaitReq (memWaitReq),
    .strobe     (strobe),
    .memWrite   (memWrite),
    .srcRead    (srcRead),
    .busy       (busy),
    .done       (done)
  );

  abw_datapath #(
    .ADDR_W         (ADDR_W),
    .CNT_W          (CNT_W),
    .MAX_BURST      (MAX_BURST),
    .ALIGN_BYTES    (ALIGN_BYTES),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .BC_W           (BC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .wordCount (wordCount),
    .memAddr   (memAddr),
    .memBurst  (memBurst),
    .remZero   (remZero),
    .lastBeat  (lastBeat)
  );

  assign memWdata = srcData;
endmodule

// File: rtl/abw_checker.sv
module abw_checker #(
  parameter int ADDR_W      = 32,
  parameter int MAX_BURST   = 16,
  parameter int ALIGN_BYTES = 16,
  parameter int BC_W        = 5,
  parameter int BPW         = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memWrite,
  input logic              memWaitReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic [BC_W-1:0]   memBurst
);
  localparam int OFF_W = $clog2(ALIGN_BYTES);
  localparam int LSB_W = $clog2(BPW);

  logic [BC_W-1:0] beatCnt;
  logic            firstPending;
  logic            accept;

  assign accept = memWrite && !memWaitReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt      <= '0;
      firstPending <= 1'b0;
    end else begin
      if (accept) beatCnt <= (BC_W'(beatCnt + 1'b1) == memBurst) ? '0 : BC_W'(beatCnt + 1'b1);
      if (start && !busy) firstPending <= 1'b1;
      else if (accept)    firstPending <= 1'b0;
    end
  end

  // R2: word addresses only
  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> memAddr[LSB_W-1:0] == '0);

  // R5: bursts after the first begin on a boundary
  p_aligned_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && beatCnt == '0 && !firstPending) |-> memAddr[OFF_W-1:0] == '0);

  // R6: burst length range
  p_burst_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memBurst != '0 && int'(memBurst) <= MAX_BURST));

  // R6: unaligned burst stops at the next boundary
  p_no_cross_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memAddr[OFF_W-1:0] != '0) |->
      (int'(memAddr[OFF_W-1:0]) + int'(memBurst) * BPW <= ALIGN_BYTES));

  // R7: header held under stall
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memWaitReq) |=> ($stable(memAddr) && $stable(memBurst)));

  // R8: single-cycle done, writes only while busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> busy);
endmodule

bind align_burst_writer abw_checker #(
  .ADDR_W      (ADDR_W),
  .MAX_BURST   (MAX_BURST),
  .ALIGN_BYTES (ALIGN_BYTES),
  .BC_W        (BC_W),
  .BPW         (DATA_W / 8)
) u_abwChecker (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .memWrite   (memWrite),
  .memWaitReq (memWaitReq),
  .memAddr    (memAddr),
  .memBurst   (memBurst)
);

// File: tb/tb_align_burst_writer.sv
`timescale 1ns/1ps
module tb_align_burst_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic [15:0] wordCount = '0;
  logic        busy, done, srcRead, srcValid, memWrite;
  logic [31:0] srcData, memAddr, memWdata;
  logic [4:0]  memBurst;
  logic        memWaitReq = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] fifo [0:63];
  int rdPtr = 0;
  int wrPtr = 0;
  logic srcHold = 1'b0;
  bit stallOn = 0, gapOn = 0;
  logic [7:0] lfsr = 8'h5B;

  logic [31:0] memModel [0:255];
  bit          wflag [0:255];
  logic [31:0] blAddr [0:31];
  int          blLen [0:31];
  int blCount, writes, beatIdx, curLen, doneCycles, doneCyc, firstWriteCyc, lastAccCyc;
  logic [31:0] curBase;

  always #2.5 clk = ~clk;

  align_burst_writer dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .wordCount(wordCount),
    .busy(busy), .done(done), .srcData(srcData), .srcValid(srcValid), .srcRead(srcRead),
    .memAddr(memAddr), .memBurst(memBurst), .memWrite(memWrite), .memWdata(memWdata),
    .memWaitReq(memWaitReq)
  );

  assign srcValid = (rdPtr != wrPtr) && !srcHold;
  assign srcData  = fifo[rdPtr % 64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (srcRead) rdPtr <= rdPtr + 1;
  end

  // Drive stall/gap inputs, then log accepted beats away from the rising edge.
  always @(negedge clk) begin
    logic [31:0] a;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    srcHold = gapOn && lfsr[2] && lfsr[5];
    memWaitReq = stallOn && lfsr[0] && lfsr[3];
    #1;
    if (rstN) begin
      if (done) begin doneCycles++; doneCyc = cyc; end
      if (memWrite && firstWriteCyc < 0) firstWriteCyc = cyc;
      if (memWrite && !memWaitReq) begin
        if (beatIdx == 0) begin
          curBase = memAddr; curLen = int'(memBurst);
          if (blCount < 32) begin blAddr[blCount] = memAddr; blLen[blCount] = int'(memBurst); end
          blCount++;
        end
        a = curBase + 32'(4 * beatIdx);
        memModel[a[9:2]] = memWdata;
        wflag[a[9:2]] = 1;
        writes++;
        lastAccCyc = cyc;
        beatIdx = (beatIdx + 1 >= curLen) ? 0 : beatIdx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic runTransfer(input logic [31:0] addr, input int count, input bit stall,
                             input bit gap, input bit midStart, input string req);
    int t = 0;
    bit inj = 0;
    int startCyc;
    int expCount = 0;
    logic [31:0] ea;
    int rem;
    @(negedge clk);
    for (int i = 0; i < 256; i++) wflag[i] = 0;
    writes = 0; blCount = 0; beatIdx = 0; doneCycles = 0;
    firstWriteCyc = -1; lastAccCyc = -1; doneCyc = -1;
    stallOn = stall; gapOn = gap;
    for (int i = 0; i < count; i++) fifo[(wrPtr + i) % 64] = 32'hC0DE_0000 + addr + 32'(i);
    wrPtr = wrPtr + count;
    startAddr = addr; wordCount = 16'(count); start = 1'b1; startCyc = cyc;
    @(negedge clk); start = 1'b0;
    while (doneCycles == 0 && t < 3000) begin
      @(negedge clk); t++;
      if (midStart && !inj && writes >= 3) begin
        startAddr = 32'h1F0; wordCount = 16'd5; start = 1'b1;
        @(negedge clk); start = 1'b0; inj = 1;
      end
    end
    repeat (4) @(negedge clk);
    #2;
    stallOn = 0; gapOn = 0;
    chk(doneCycles == 1, "R8", {req, " done pulse count"}, doneCycles, 1);
    chk(busy == 1'b0, "R8", {req, " busy after done"}, busy, 0);
    chk(writes == count, (midStart ? "R10" : "R2"), {req, " write total"}, writes, count);
    if (count == 0) begin
      chk(doneCyc == startCyc + 2, "R9", {req, " zero-count done cycle"}, doneCyc, startCyc + 2);
    end else begin
      chk(doneCyc - lastAccCyc == 2, "R8", {req, " done after last beat"}, doneCyc - lastAccCyc, 2);
      if (!gap)
        chk(firstWriteCyc == startCyc + 2, "R8", {req, " first beat cycle"}, firstWriteCyc, startCyc + 2);
    end
    for (int i = 0; i < count; i++) begin
      ea = addr + 32'(4 * i);
      chk(wflag[ea[9:2]] && memModel[ea[9:2]] == 32'hC0DE_0000 + addr + 32'(i), "R2",
          {req, " stored word"}, memModel[ea[9:2]], 32'hC0DE_0000 + addr + 32'(i));
    end
    // Expected burst list from the splitting rules
    ea = addr; rem = count;
    while (rem > 0) begin
      int room = (ea[3:0] == 4'h0) ? 16 : (16 - int'(ea[3:0])) / 4;
      int len = (rem < room) ? rem : room;
      if (expCount < blCount && expCount < 32) begin
        chk(blAddr[expCount] == ea,
            (expCount == 0) ? ((addr[3:0] != 0) ? "R3" : "R4") : "R5",
            {req, " burst address"}, blAddr[expCount], ea);
        chk(blLen[expCount] == len,
            (expCount == 0) ? ((addr[3:0] != 0) ? "R3" : "R4") : "R5",
            {req, " burst length"}, blLen[expCount], len);
      end
      expCount++; ea = ea + 32'(4 * len); rem = rem - len;
    end
    chk(blCount == expCount, "R5", {req, " burst count"}, blCount, expCount);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(memWrite == 0 && busy == 0 && done == 0, "R1", "outputs in reset",
        {memWrite, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(memWrite == 0 && busy == 0 && done == 0, "R1", "outputs after reset",
        {memWrite, busy, done}, 0);
  endtask

  task automatic test_aligned_start();
    runTransfer(32'h100, 11, 0, 0, 0, "R4 aligned 11");
    runTransfer(32'h140, 16, 0, 0, 0, "R4 aligned 16");
  endtask

  task automatic test_unaligned_starts();
    for (int off = 4; off < 16; off += 4)
      runTransfer(32'h100 + 32'(off), 11, 0, 0, 0, "R3 offset start");
  endtask

  task automatic test_long_with_stall();
    runTransfer(32'h108, 37, 1, 0, 0, "R5 R7 long stalled");
  endtask

  task automatic test_short_counts();
    runTransfer(32'h10C, 1, 0, 0, 0, "R3 single word");
    runTransfer(32'h104, 2, 0, 0, 0, "R3 count below room");
    runTransfer(32'h100, 17, 0, 0, 0, "R5 one word tail");
  endtask

  task automatic test_zero_count();
    runTransfer(32'h104, 0, 0, 0, 0, "R9 zero count");
  endtask

  task automatic test_start_while_busy();
    runTransfer(32'h104, 20, 1, 0, 1, "R10 start while busy");
  endtask

  task automatic test_source_gaps();
    runTransfer(32'h108, 23, 1, 1, 0, "R7 source gaps");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    test_reset();
    test_aligned_start();
    test_unaligned_starts();
    test_long_with_stall();
    test_short_counts();
    test_zero_count();
    test_start_while_busy();
    test_source_gaps();
    finishRun();
  end
endmodule